// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

The block adds two unsigned words one bit per clock, least significant bit first, using a single full adder and one carry flip-flop in place of a ripple or look-ahead carry chain. Two right-shifting registers hold the operands. On each enabled shift the low bits of both registers and the stored carry enter the full adder. The sum bit enters the top of the first register, and the carry-out is kept for the next bit. After one word time the first register holds the sum in place.

A start pulse loads both operands in parallel, clears the carry and arms the sequence. While shifting, the second register takes fresh bits from an external serial input at its top, so it can be refilled with the next operand during the addition. The shift enable may be dropped for any number of cycles to pause the sequence. An internal step counter ends the sequence after exactly `W` enabled shifts and flags completion for one cycle. The final carry flip-flop value is the carry-out of the addition.

Top module: `serial_add_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `reg_a`, `reg_b`, `carry` and `done` all zero, and the block is idle.
- R2: A cycle with `start` high loads `reg_a` from `opa_in` and `reg_b` from `opb_in`, clears `carry` and `done`, and begins a new sequence. `start` takes priority over shifting, even in the middle of an addition.
- R3: After `W` enabled shift cycles following a load, `reg_a` equals `(opa + opb) mod 2^W`.
- R4: After those `W` shifts, `carry` equals bit `W` of `opa + opb` (the carry-out).
- R5: On every enabled shift, `reg_b` moves right by one bit and `ser_in` enters bit `W-1`. After `W` shifts, the bit that entered on the first shift is in bit 0.
- R6: During a sequence, a cycle with `shift_en` low leaves `reg_a`, `reg_b` and `carry` unchanged. The sequence then resumes where it paused.
- R7: `done` is high for exactly the one cycle that follows the `W`-th shift. After that the block is idle, and `shift_en` has no effect on `reg_a`, `reg_b` or `carry` until the next `start`.
- R8: After `k` enabled shifts (0 < k < W), `reg_a` holds the low `k` sum bits in its top `k` positions above `opa >> k`. `carry` holds the carry out of the low `k` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load operands, clear carry, begin sequence |
| opa_in | input | W | Parallel operand for register A |
| opb_in | input | W | Parallel operand for register B |
| shift_en | input | 1 | Advances one bit step while a sequence is active |
| ser_in | input | 1 | Serial bit entering the top of register B |
| reg_a | output | W | Register A: operand, partial sum, then final sum |
| reg_b | output | W | Register B contents |
| carry | output | 1 | Carry flip-flop; final value is the carry-out |
| done | output | 1 | One-cycle pulse after the last shift |

## Verification
The operand pairs cover a case with a carry that travels into the middle bits and then dies out, which tests that the carry is reused correctly from bit to bit. Other pairs are an all-ones plus one that wraps to zero, all zeros, all ones plus all ones, and disjoint bit patterns that produce no carry at all. Each pair is checked after every single shift, so a wrong bit order or a stale carry shows up at the step where it occurs, not only at the end. The serial stream for register B differs from pair to pair, which separates "refilled from the serial input" from "recirculated" or "zero-filled". Pauses inside a sequence, extra shifts after completion, and a restart during an addition each test a separate part of the sequencing control.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    // Operation applied to an operand shift register in a given cycle.
    typedef enum logic [1:0] {
        SR_HOLD  = 2'd0,
        SR_LOAD  = 2'd1,
        SR_SHIFT = 2'd2
    } sr_op_e;

endpackage

// File: rtl/sadd_fa.sv
module sadd_fa (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic half_s;

    always_comb begin
        half_s = a ^ b;
        sum    = half_s ^ cin;
        cout   = (a & b) | (half_s & cin);
    end
endmodule

// File: rtl/sadd_shreg.sv
module sadd_shreg
    import sadd_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sr_op_e       op,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] q,
    output logic         ser_out
);
    typedef struct packed {
        logic [W-1:0] bits;
    } sr_state_t;

    sr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            SR_LOAD:  st_d.bits = par_in;
            SR_SHIFT: st_d.bits = {ser_in, st_q.bits[W-1:1]};
            default:  st_d.bits = st_q.bits;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q       = st_q.bits;
    assign ser_out = st_q.bits[0];
endmodule

// File: rtl/sadd_seq.sv
module sadd_seq
    import sadd_pkg::*;
#(
    parameter int W = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   shift_en,
    output sr_op_e op,
    output logic   busy,
    output logic   done
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] step;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            op        = SR_LOAD;
            st_d.busy = 1'b1;
            st_d.step = '0;
        end else if (st_q.busy && shift_en) begin
            op        = SR_SHIFT;
            st_d.step = st_q.step + 1'b1;
            if (st_q.step == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.step = '0;
            end
        end else begin
            op = SR_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
endmodule

// File: rtl/serial_add_unit.sv
module serial_add_unit
    import sadd_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] opa_in,
    input  logic [W-1:0] opb_in,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [W-1:0] reg_a,
    output logic [W-1:0] reg_b,
    output logic         carry,
    output logic         done
);
    typedef struct packed {
        logic cy;
    } cy_state_t;

    sr_op_e    op;
    logic      busy;
    logic      a_bit, b_bit;
    logic      sum_bit, cy_out;
    cy_state_t cy_d, cy_q;

    sadd_seq #(.W(W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .shift_en (shift_en),
        .op       (op),
        .busy     (busy),
        .done     (done)
    );

    sadd_shreg #(.W(W)) u_reg_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .par_in  (opa_in),
        .ser_in  (sum_bit),
        .q       (reg_a),
        .ser_out (a_bit)
    );

    sadd_shreg #(.W(W)) u_reg_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .par_in  (opb_in),
        .ser_in  (ser_in),
        .q       (reg_b),
        .ser_out (b_bit)
    );

    sadd_fa u_fa (
        .a    (a_bit),
        .b    (b_bit),
        .cin  (cy_q.cy),
        .sum  (sum_bit),
        .cout (cy_out)
    );

    always_comb begin
        cy_d = cy_q;
        unique case (op)
            SR_LOAD:  cy_d.cy = 1'b0;
            SR_SHIFT: cy_d.cy = cy_out;
            default:  cy_d.cy = cy_q.cy;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cy_q <= '0;
        end else begin
            cy_q <= cy_d;
        end
    end

    assign carry = cy_q.cy;
endmodule

// File: rtl/sadd_checker.sv
module sadd_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         shift_en,
    input logic         ser_in,
    input logic [W-1:0] opa_in,
    input logic [W-1:0] opb_in,
    input logic [W-1:0] reg_a,
    input logic [W-1:0] reg_b,
    input logic         carry,
    input logic         done,
    input logic         busy
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (reg_a == '0 && reg_b == '0 && !carry && !done && !busy));

    // R2
    a_r2_load_takes_operands: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (reg_a == $past(opa_in) && reg_b == $past(opb_in) && !carry && !done));

    // R5
    a_r5_serial_enters_top: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && shift_en && !start) |=> (reg_b[W-1] == $past(ser_in)));

    // R6
    a_r6_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_en && !start) |=> ($stable(reg_a) && $stable(reg_b) && $stable(carry)));

    // R7
    a_r7_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_idle_ignores_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(reg_a) && $stable(reg_b) && $stable(carry)));
endmodule

bind serial_add_unit sadd_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .opa_in   (opa_in),
    .opb_in   (opb_in),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .carry    (carry),
    .done     (done),
    .busy     (busy)
);

// File: tb/serial_add_unit_test.sv
module serial_add_unit_test;
    localparam int W = 4;
    localparam int NV = 6;
    // Entry: {pause_after_first_shift, opa, opb, serial word}
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 4'b0100, 4'b0111, 4'b1010},
        {1'b1, 4'b1111, 4'b0001, 4'b0101},
        {1'b0, 4'b0000, 4'b0000, 4'b1111},
        {1'b1, 4'b1111, 4'b1111, 4'b0000},
        {1'b0, 4'b1001, 4'b0110, 4'b1100},
        {1'b1, 4'b0111, 4'b1011, 4'b0011}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] opa_in = '0;
    logic [W-1:0] opb_in = '0;
    logic         shift_en = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] reg_a, reg_b;
    logic         carry, done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    serial_add_unit #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opa_in(opa_in), .opb_in(opb_in),
        .shift_en(shift_en), .ser_in(ser_in), .reg_a(reg_a), .reg_b(reg_b),
        .carry(carry), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input int a, input int b);
        start  = 1'b1;
        opa_in = W'(a);
        opb_in = W'(b);
        tick();
        start = 1'b0;
        check("R2 load A", int'(reg_a), a);
        check("R2 load B", int'(reg_b), b);
        check("R2 carry cleared", int'(carry), 0);
        check("R2 done low", int'(done), 0);
    endtask

    task automatic run_add(input int a, input int b, input int ser, input bit pause);
        int sum;
        int mask;
        int part_a;
        int part_c;
        sum = a + b;
        load(a, b);
        for (int k = 1; k <= W; k++) begin
            shift_en = 1'b1;
            ser_in   = ser[k-1];
            tick();
            mask   = (1 << k) - 1;
            part_c = ((a & mask) + (b & mask)) >> k;
            if (k < W) begin
                part_a = (((sum & mask) << (W - k)) | (a >> k)) & ((1 << W) - 1);
                check("R8 partial A", int'(reg_a), part_a);
                check("R8 partial carry", int'(carry), part_c);
                check("R7 done low mid-run", int'(done), 0);
                if (pause && k == 1) begin
                    shift_en = 1'b0;
                    ser_in   = ~ser_in;
                    tick();
                    check("R6 pause A", int'(reg_a), part_a);
                    check("R6 pause carry", int'(carry), part_c);
                    check("R6 pause B", int'(reg_b), ((b >> 1) | (ser[0] << (W - 1))));
                end
            end
        end
        check("R3 sum", int'(reg_a), sum & ((1 << W) - 1));
        check("R4 carry-out", int'(carry), (sum >> W) & 1);
        check("R5 refilled B", int'(reg_b), ser);
        check("R7 done pulse", int'(done), 1);
        shift_en = 1'b1;
        ser_in   = ~ser[0];
        tick();
        check("R7 done drops", int'(done), 0);
        check("R7 idle A", int'(reg_a), sum & ((1 << W) - 1));
        check("R7 idle B", int'(reg_b), ser);
        check("R7 idle carry", int'(carry), (sum >> W) & 1);
        shift_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        check("R1 reset A", int'(reg_a), 0);
        check("R1 reset B", int'(reg_b), 0);
        check("R1 reset carry", int'(carry), 0);
        check("R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        shift_en = 1'b1;
        ser_in = 1'b1;
        tick();
        check("R7 no run before start", int'(reg_b), 0);
        shift_en = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_add(int'(VEC[i][11:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]), VEC[i][12]);
        end

        // R2: restart mid-addition, start wins over shift
        load(5, 6);
        shift_en = 1'b1;
        ser_in = 1'b1;
        tick();
        tick();
        start = 1'b1;
        opa_in = 4'd3;
        opb_in = 4'd9;
        tick();
        start = 1'b0;
        check("R2 restart A", int'(reg_a), 3);
        check("R2 restart B", int'(reg_b), 9);
        check("R2 restart carry", int'(carry), 0);
        shift_en = 1'b0;
        run_add(3, 9, 4'b0110, 1'b0);

        // R1: reset in the middle of a sequence
        load(15, 15);
        shift_en = 1'b1;
        tick();
        rst_n = 1'b0;
        tick();
        check("R1 mid reset A", int'(reg_a), 0);
        check("R1 mid reset carry", int'(carry), 0);
        rst_n = 1'b1;
        tick();
        check("R1 idle after reset B", int'(reg_b), 0);
        check("R1 idle after reset done", int'(done), 0);
        shift_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule